// File: doc/BRIEF.md
# Speculative-Wakeup Issue Queue

This block holds decoded micro-ops until their operands are ready, then picks the oldest ready ones each cycle and sends them to a fixed number of issue lanes. Each slot keeps an opaque payload, a destination tag, two source tags and a readiness state for each source. Result tags arrive on a broadcast input and are compared at once against every source tag in the queue. A source whose ready bit is set makes a slot a candidate in the same cycle, so a broadcast can wake a slot and issue it in one cycle.

Loads are handled optimistically. When a load issues, the queue itself broadcasts the load's destination tag a fixed hit latency later (4 cycles by default), without waiting for the data. Sources woken this way are marked as speculative. A slot that issues while any of its sources is still speculative stays in the queue. A later response on the load's tag either confirms it, which frees the slot, or reports a miss. A miss clears the affected ready bit and the issued flag, so the slot waits for a real broadcast and issues again with its original age.

Dispatch accepts one micro-op per cycle into the lowest-numbered free slot. When no slot is free, the dispatch-ready output is low.

Top module: `iq_spec_issue`

## Requirements
- R1: An issued slot presents on its lane the payload and destination tag that were written at dispatch.
- R2: A source tag of 0 means the operand is ready when the slot is allocated.
- R3: A real broadcast whose tag equals a source tag of a valid slot sets that source ready, and the slot can issue in the same cycle as the broadcast.
- R4: A slot requests issue only when both of its sources are ready. One ready source alone never issues it.
- R5: A broadcast that matches a dispatching micro-op's source in its dispatch cycle is kept. A dispatched micro-op issues at the earliest in the cycle after dispatch.
- R6: Up to ISSUE_W slots issue per cycle in allocation order, oldest first. Lane 0 carries the oldest granted slot, and slot index has no effect on priority.
- R7: dispatch_ready is high exactly when at least one slot is free. It is high during reset.
- R8: A load issued on lane k in cycle T drives spec_valid[k] with its destination tag in cycle T+HIT_LAT. That broadcast wakes matching sources as speculative.
- R9: A slot that issues with a speculative source stays allocated until a hit response on that source's tag, and is then freed.
- R10: A miss response on a tag clears every source woken speculatively by that tag, together with the issued flag of its slot. The slot then issues again only after a new broadcast of the tag, still ahead of younger slots.
- R11: A slot that issues with no speculative source is freed at the end of its issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_payload | input | PAY_W | Opaque micro-op payload |
| disp_dst | input | TAG_W | Destination tag |
| disp_src0 | input | TAG_W | First source tag (0 = none) |
| disp_src1 | input | TAG_W | Second source tag (0 = none) |
| disp_is_load | input | 1 | Micro-op is a load |
| disp_ready | output | 1 | A free slot exists |
| bc_valid | input | 1 | Real result broadcast valid |
| bc_tag | input | TAG_W | Real result tag |
| resp_valid | input | 1 | Load outcome valid |
| resp_tag | input | TAG_W | Tag of the load being resolved |
| resp_miss | input | 1 | 1 = miss (replay), 0 = hit (confirm) |
| iss_valid | output | ISSUE_W | Per-lane issue valid |
| iss_payload | output | ISSUE_W*PAY_W | Per-lane payload, lane k at bits k*PAY_W |
| iss_dst | output | ISSUE_W*TAG_W | Per-lane destination tag |
| spec_valid | output | ISSUE_W | Per-lane speculative load broadcast |
| spec_tag | output | ISSUE_W*TAG_W | Tag of the speculative broadcast |

## Verification
The assertions rely on a few things about the inputs. A load's response arrives only after its speculative broadcast. In-flight producers carry distinct tags. A miss never shares its cycle with a real broadcast of the same tag or with the grant of a dependent woken by it. Dispatch is requested only while dispatch_ready is high. The stimulus is a fixed cycle script in which every response trails its speculative wakeup by at least two cycles. Each tag is reused only after all of its consumers have left the queue, and the full-queue phase stops dispatching as soon as the ready output falls.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Readiness of one operand: rdy = value available, spec = woken by an unconfirmed load
  typedef struct packed {
    logic rdy;
    logic spec;
  } src_st_t;
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int NT    = 4,
  parameter int NB    = 2,
  parameter int TAG_W = 5
) (
  input  logic [TAG_W-1:0] tag     [NT],
  input  logic [NB-1:0]    bv,
  input  logic [TAG_W-1:0] bt      [NB],
  input  logic [NB-1:0]    bspec,
  output logic [NT-1:0]    hit_real,
  output logic [NT-1:0]    hit_spec
);
  always_comb begin
    hit_real = '0;
    hit_spec = '0;
    for (int t = 0; t < NT; t++) begin
      for (int b = 0; b < NB; b++) begin
        if (bv[b] && (bt[b] == tag[t]) && (tag[t] != '0)) begin
          if (bspec[b]) hit_spec[t] = 1'b1;
          else          hit_real[t] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iq_spec_timer.sv
module iq_spec_timer #(
  parameter int LANES = 2,
  parameter int TAG_W = 5,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] fire,
  input  logic [TAG_W-1:0] fire_tag [LANES],
  output logic [LANES-1:0] out_v,
  output logic [TAG_W-1:0] out_tag  [LANES]
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LAT-1:0]   v_q, v_d;
    logic [TAG_W-1:0] t_q [LAT];
    logic [TAG_W-1:0] t_d [LAT];

    always_comb begin
      v_d[0] = fire[k];
      t_d[0] = fire_tag[k];
      for (int s = 1; s < LAT; s++) begin
        v_d[s] = v_q[s-1];
        t_d[s] = t_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      for (int s = 0; s < LAT; s++) begin
        if (v_d[s]) t_q[s] <= t_d[s];
      end
    end

    assign out_v[k]   = v_q[LAT-1];
    assign out_tag[k] = t_q[LAT-1];
  end
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] vld,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt [LANES]
);
  // older_q[i][j] = 1 when slot j was allocated before slot i
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];
  logic [LANES-1:0] col [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc[i]) older_d[i] = vld & ~(N'(1) << i);
      else          older_d[i] = older_q[i] & ~alloc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      older_q <= older_d;
    end
  end

  always_comb begin
    logic [N-1:0] cand;
    logic [N-1:0] g;
    cand = req;
    for (int k = 0; k < LANES; k++) begin
      g = '0;
      for (int i = 0; i < N; i++) begin
        g[i] = cand[i] && ((older_q[i] & cand) == '0);
      end
      gnt[k] = g;
      cand   = cand & ~g;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < LANES; k++) col[i][k] = gnt[k][i];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_ONE_LANE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[i])); // R6
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      AST_AGE_TOTAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[i] && vld[j]) |-> (older_q[i][j] != older_q[j][i])); // R6
    end
  end
endmodule

// File: rtl/iq_spec_issue.sv
module iq_spec_issue
  import iq_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 5,
  parameter int PAY_W   = 8,
  parameter int ISSUE_W = 2,
  parameter int HIT_LAT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic [PAY_W-1:0]           disp_payload,
  input  logic [TAG_W-1:0]           disp_dst,
  input  logic [TAG_W-1:0]           disp_src0,
  input  logic [TAG_W-1:0]           disp_src1,
  input  logic                       disp_is_load,
  output logic                       disp_ready,
  input  logic                       bc_valid,
  input  logic [TAG_W-1:0]           bc_tag,
  input  logic                       resp_valid,
  input  logic [TAG_W-1:0]           resp_tag,
  input  logic                       resp_miss,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*PAY_W-1:0]   iss_payload,
  output logic [ISSUE_W*TAG_W-1:0]   iss_dst,
  output logic [ISSUE_W-1:0]         spec_valid,
  output logic [ISSUE_W*TAG_W-1:0]   spec_tag
);
  localparam int NT = 2 * ENTRIES + 2;   // all slot sources plus the two dispatch sources
  localparam int NB = 1 + ISSUE_W;       // one real broadcast plus one speculative per lane
  localparam int DSP = 2 * ENTRIES;      // index of the dispatch sources in the tag list

  // slot state
  logic [ENTRIES-1:0] vld_q, vld_d, iss_q, iss_d, ld_q;
  logic [PAY_W-1:0]   pay_q  [ENTRIES];
  logic [TAG_W-1:0]   dst_q  [ENTRIES];
  logic [TAG_W-1:0]   stag_q [ENTRIES][2];
  src_st_t            sst_q  [ENTRIES][2];
  src_st_t            sst_d  [ENTRIES][2];
  src_st_t            wake   [ENTRIES][2];

  logic [ENTRIES-1:0] alloc_pick, alloc, req, gnt_any;
  logic [ENTRIES-1:0] gnt [ISSUE_W];

  logic [NB-1:0]      bv, bspec;
  logic [TAG_W-1:0]   bt    [NB];
  logic [TAG_W-1:0]   tlist [NT];
  logic [NT-1:0]      hr, hs;

  logic [ISSUE_W-1:0] iv, il, sv;
  logic [TAG_W-1:0]   idst [ISSUE_W];
  logic [PAY_W-1:0]   ipay [ISSUE_W];
  logic [TAG_W-1:0]   st_tag [ISSUE_W];
  logic [TAG_W-1:0]   dsrc [2];

  assign dsrc[0] = disp_src0;
  assign dsrc[1] = disp_src1;

  // allocation: lowest free slot
  always_comb begin
    alloc_pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_pick = ENTRIES'(1) << i;
    end
  end
  assign disp_ready = |(~vld_q);
  assign alloc      = disp_valid ? alloc_pick : '0;

  // broadcast bus and tag list for the match array
  always_comb begin
    bv[0] = bc_valid;  bt[0] = bc_tag;  bspec[0] = 1'b0;
    for (int k = 0; k < ISSUE_W; k++) begin
      bv[1+k] = sv[k];  bt[1+k] = st_tag[k];  bspec[1+k] = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      tlist[2*i]   = stag_q[i][0];
      tlist[2*i+1] = stag_q[i][1];
    end
    tlist[DSP]   = disp_src0;
    tlist[DSP+1] = disp_src1;
  end

  iq_tag_match #(.NT(NT), .NB(NB), .TAG_W(TAG_W)) u_match (
    .tag(tlist), .bv(bv), .bt(bt), .bspec(bspec), .hit_real(hr), .hit_spec(hs)
  );

  // wakeup: a real match confirms, a speculative match only fills an empty operand
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      for (int s = 0; s < 2; s++) begin
        wake[i][s] = sst_q[i][s];
        if (hr[2*i+s]) begin
          wake[i][s].rdy  = 1'b1;
          wake[i][s].spec = 1'b0;
        end else if (hs[2*i+s] && !sst_q[i][s].rdy) begin
          wake[i][s].rdy  = 1'b1;
          wake[i][s].spec = 1'b1;
        end
      end
      req[i] = vld_q[i] && !iss_q[i] && wake[i][0].rdy && wake[i][1].rdy;
    end
  end

  iq_age_select #(.N(ENTRIES), .LANES(ISSUE_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .vld(vld_q), .req(req), .gnt(gnt)
  );

  // next state: resolve responses, then release, then allocate
  always_comb begin
    logic replay;
    gnt_any = '0;
    for (int k = 0; k < ISSUE_W; k++) gnt_any = gnt_any | gnt[k];
    for (int i = 0; i < ENTRIES; i++) begin
      replay = 1'b0;
      for (int s = 0; s < 2; s++) begin
        sst_d[i][s] = wake[i][s];
        if (resp_valid && wake[i][s].spec && (stag_q[i][s] == resp_tag)) begin
          sst_d[i][s].spec = 1'b0;
          if (resp_miss) begin
            sst_d[i][s].rdy = 1'b0;
            replay          = 1'b1;
          end
        end
      end
      iss_d[i] = replay ? 1'b0 : (iss_q[i] | gnt_any[i]);
      vld_d[i] = vld_q[i] && !(iss_d[i] && !sst_d[i][0].spec && !sst_d[i][1].spec);
      if (alloc[i]) begin
        vld_d[i] = 1'b1;
        iss_d[i] = 1'b0;
        for (int s = 0; s < 2; s++) begin
          sst_d[i][s].rdy  = (dsrc[s] == '0) || hr[DSP+s] || hs[DSP+s];
          sst_d[i][s].spec = hs[DSP+s] && !hr[DSP+s] && (dsrc[s] != '0);
        end
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      iss_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        sst_q[i][0] <= '0;
        sst_q[i][1] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      iss_q <= iss_d;
      sst_q <= sst_d;
    end
  end

  // payload registers, written only on allocation
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc[i]) begin
        pay_q[i]     <= disp_payload;
        dst_q[i]     <= disp_dst;
        stag_q[i][0] <= disp_src0;
        stag_q[i][1] <= disp_src1;
        ld_q[i]      <= disp_is_load;
      end
    end
  end

  // issue lane muxes
  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      iv[k] = 1'b0;  il[k] = 1'b0;  idst[k] = '0;  ipay[k] = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (gnt[k][i]) begin
          iv[k]   = 1'b1;
          il[k]   = ld_q[i];
          idst[k] = dst_q[i];
          ipay[k] = pay_q[i];
        end
      end
    end
  end

  iq_spec_timer #(.LANES(ISSUE_W), .TAG_W(TAG_W), .LAT(HIT_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(iv & il), .fire_tag(idst), .out_v(sv), .out_tag(st_tag)
  );

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
    assign iss_payload[k*PAY_W +: PAY_W] = ipay[k];
    assign iss_dst[k*TAG_W +: TAG_W]     = idst[k];
    assign spec_tag[k*TAG_W +: TAG_W]    = st_tag[k];
  end
  assign iss_valid  = iv;
  assign spec_valid = sv;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc[i] |-> !vld_q[i]); // R7
    AST_ISSUED_HOLDS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && iss_q[i]) |-> (sst_q[i][0].spec || sst_q[i][1].spec)); // R9
    AST_MISS_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_miss && vld_q[i] && !alloc[i] && !(bc_valid && bc_tag == resp_tag) &&
       ((sst_q[i][0].spec && stag_q[i][0] == resp_tag) ||
        (sst_q[i][1].spec && stag_q[i][1] == resp_tag))) |=> !iss_q[i]); // R10
  end
endmodule

// File: tb/tb_iq_spec_issue.sv
module tb_iq_spec_issue;
  localparam int EN = 8, TW = 5, PW = 8, IW = 2, LAT = 4;
  localparam int LAST = 72;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_is_load, disp_ready;
  logic [PW-1:0] disp_payload;
  logic [TW-1:0] disp_dst, disp_src0, disp_src1, bc_tag, resp_tag;
  logic bc_valid, resp_valid, resp_miss;
  logic [IW-1:0] iss_valid, spec_valid;
  logic [IW*PW-1:0] iss_payload;
  logic [IW*TW-1:0] iss_dst, spec_tag;

  int checks = 0, errors = 0, n3 = 0, n4 = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iq_spec_issue #(.ENTRIES(EN), .TAG_W(TW), .PAY_W(PW), .ISSUE_W(IW), .HIT_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_payload(disp_payload),
    .disp_dst(disp_dst), .disp_src0(disp_src0), .disp_src1(disp_src1),
    .disp_is_load(disp_is_load), .disp_ready(disp_ready), .bc_valid(bc_valid),
    .bc_tag(bc_tag), .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_miss(resp_miss),
    .iss_valid(iss_valid), .iss_payload(iss_payload), .iss_dst(iss_dst),
    .spec_valid(spec_valid), .spec_tag(spec_tag)
  );

  function automatic logic [PW-1:0] pay_of(int d);
    return PW'((d * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_is_load = 0; disp_payload = '0; disp_dst = '0;
    disp_src0 = '0; disp_src1 = '0; bc_valid = 0; bc_tag = '0;
    resp_valid = 0; resp_tag = '0; resp_miss = 0;
  endtask

  task automatic disp(int d, int s0, int s1, bit ld);
    disp_valid = 1; disp_dst = TW'(d); disp_src0 = TW'(s0); disp_src1 = TW'(s1);
    disp_is_load = ld; disp_payload = pay_of(d);
  endtask

  task automatic bcast(int t);
    bc_valid = 1; bc_tag = TW'(t);
  endtask

  task automatic resp(int t, bit miss);
    resp_valid = 1; resp_tag = TW'(t); resp_miss = miss;
  endtask

  // expected issue dst per cycle and lane, -1 = none
  function automatic int exp_iss(int c, int lane);
    if (lane == 0) begin
      case (c)
        1: return 1;   5: return 2;   9: return 3;  13: return 4;
        20: return 3; 24: return 4;  33: return 10; 36: return 13;
        41: return 8; 42: return 11; 43: return 14; 44: return 16;
        51: return 20; 58: return 22; 59: return 21; 65: return 23;
        default: return -1;
      endcase
    end
    case (c)
      41: return 9; 42: return 12; 43: return 15; 44: return 17; 65: return 24;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_spec(int c, int lane);
    if (lane == 0) begin
      case (c)
        5: return 1; 9: return 2; 13: return 3; 24: return 3; 69: return 23;
        default: return -1;
      endcase
    end
    return (c == 69) ? 24 : -1;
  endfunction

  function automatic string phase_rq(int c);
    if (c < 28) return "R2 R3 R8 R10";
    if (c < 47) return "R3 R6";
    if (c < 61) return "R3 R4 R5";
    return "R6 R8";
  endfunction

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    #2;
    check(iss_valid == '0, "R6", "reset iss_valid", int'(iss_valid), 0);
    check(disp_ready == 1'b1, "R7", "reset disp_ready", int'(disp_ready), 1);
    check(spec_valid == '0, "R8", "reset spec_valid", int'(spec_valid), 0);
    for (int c = 0; c <= LAST; c++) begin
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      case (c)
        0: disp(1, 0, 0, 1);
        1: disp(2, 1, 0, 1);
        2: disp(3, 2, 0, 1);
        3: disp(4, 3, 0, 0);
        7: resp(1, 0);
        14: resp(2, 1);
        15: resp(3, 1);
        20: bcast(2);
        26: resp(3, 0);
        41: bcast(30);
        50: begin disp(20, 25, 0, 0); bcast(25); end
        52: bcast(26);
        53: disp(21, 26, 0, 0);
        55: disp(22, 27, 28, 0);
        57: bcast(27);
        58: bcast(28);
        59: bcast(26);
        62: disp(23, 29, 0, 1);
        63: disp(24, 29, 0, 1);
        65: bcast(29);
        default: ;
      endcase
      if (c >= 30 && c <= 39)
        disp(8 + (c - 30), ((c - 30) == 2 || (c - 30) == 5) ? 0 : 30, 0, 0);
      #2;
      for (int k = 0; k < IW; k++) begin
        int e, a, es, as;
        e  = exp_iss(c, k);
        a  = iss_valid[k] ? int'(iss_dst[k*TW +: TW]) : -1;
        check(a == e, phase_rq(c), $sformatf("cycle %0d lane %0d issue dst", c, k), a, e);
        if (iss_valid[k]) begin
          check(iss_payload[k*PW +: PW] == pay_of(a), "R1",
                $sformatf("cycle %0d lane %0d payload", c, k),
                int'(iss_payload[k*PW +: PW]), int'(pay_of(a)));
          if (a == 3) n3++;
          if (a == 4) n4++;
        end
        es = exp_spec(c, k);
        as = spec_valid[k] ? int'(spec_tag[k*TW +: TW]) : -1;
        check(as == es, "R8", $sformatf("cycle %0d lane %0d spec tag", c, k), as, es);
      end
      check(disp_ready == !(c == 40 || c == 41), "R7 R9 R11",
            $sformatf("cycle %0d disp_ready", c), int'(disp_ready), int'(!(c == 40 || c == 41)));
    end
    check(n3 == 2, "R10", "issues of replayed load tag 3", n3, 2);
    check(n4 == 2, "R10", "issues of replayed dependent tag 4", n4, 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule